// File: doc/BRIEF.md
# Programmable Interlaced Video Timing Generator

This block produces raster timing for a video output running in the pixel clock domain. From a set of programmed parameters it drives horizontal sync, vertical sync, a data-enable strobe, a field identifier and live pixel and line counters. The parameters are:

- the active width and active height;
- three horizontal blanking widths (front porch, sync, back porch);
- a separate set of vertical front porch, sync and back porch values for each of the two fields;
- an interlace enable, a two-bit polarity mask and a half-line flag.

Software presents a complete parameter set on the configuration inputs and pulses a commit strobe. The block checks the set, holds it in a pending buffer and switches to it only when the current frame ends. The raster therefore never tears in the middle of a field. In interlaced mode each field carries half of the active height. When the half-line flag is set, the vertical sync of the first field is moved half a line later, which balances the half-line count of the two fields.

Top module: `scan_timing_gen`

## Requirements
- R1: `hcount` counts 0 up to htot-1 and then wraps to 0, where htot = active width + front porch + sync + back porch, all in pixels.
- R2: Horizontal sync is asserted while hact+hfp <= `hcount` < hact+hfp+hsw. Polarity bit 1 sets its level: 1 means high while asserted, 0 means low while asserted.
- R3: `de` is 1 exactly when `hcount` < active width and `vcount` < the field's active lines. The field's active lines are the active height in progressive mode and floor(active height / 2) in interlaced mode.
- R4: `vcount` counts 0 up to L-1 and then wraps to 0. L is the field's active lines plus its vertical front porch, sync and back porch. Field 0 uses the first-field set. Field 1 uses the second-field set. Progressive mode uses only the first-field set.
- R5: Vertical sync is asserted while A+vfp <= `vcount` < A+vfp+vsw, using the current field's values, where A is the field's active lines. Polarity bit 0 sets its level: 1 means high while asserted.
- R6: `field` is 0 during the first field and 1 during the second. In interlaced mode it toggles when a field's last pixel ends. In progressive mode it stays 0.
- R7: With interlace and the half-line flag both set, field 0's vertical sync starts at `hcount` = floor(htot/2) of line A+vfp and ends at that same pixel of line A+vfp+vsw. Field 1 is unaffected by the flag. In progressive mode the flag has no effect.
- R8: A commit made in progressive mode with any nonzero second-field vertical value is rejected. `cfg_err` is 1 for the single cycle after the commit, and the rejected set is discarded. An earlier accepted set that is still pending is kept.
- R9: An accepted set takes effect at the next frame start: field 0, line 0, pixel 0. In interlaced mode that is after field 1 ends. In progressive mode it is after every field. If several sets are accepted within one frame, the last one wins. A commit made in the frame's last cycle applies one frame later.
- R10: Synchronous active-low reset clears the counters and `field` to 0, clears `cfg_err` and any pending set, and loads this configuration: width 8, hfp 2, hsw 2, hbp 2, height 4, first-field 1/1/1, second-field 0/0/0, progressive, no half-line, polarity 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_commit | input | 1 | One-cycle strobe that submits the configuration inputs |
| cfg_ilace | input | 1 | 1 selects interlaced scanning |
| cfg_half | input | 1 | Half-line vertical sync placement for the first field |
| cfg_pol | input | 2 | Bit 1 horizontal, bit 0 vertical sync polarity, 1 = high while asserted |
| cfg_hact | input | HW | Active pixels per line |
| cfg_hfp | input | HW | Horizontal front porch, pixels |
| cfg_hsw | input | HW | Horizontal sync width, pixels |
| cfg_hbp | input | HW | Horizontal back porch, pixels |
| cfg_vact | input | VW | Active lines per frame |
| cfg_f1_vfp | input | VW | First-field vertical front porch, lines |
| cfg_f1_vsw | input | VW | First-field vertical sync width, lines |
| cfg_f1_vbp | input | VW | First-field vertical back porch, lines |
| cfg_f2_vfp | input | VW | Second-field vertical front porch, lines |
| cfg_f2_vsw | input | VW | Second-field vertical sync width, lines |
| cfg_f2_vbp | input | VW | Second-field vertical back porch, lines |
| cfg_err | output | 1 | One-cycle pulse after a rejected commit |
| hsync | output | 1 | Horizontal sync at programmed polarity |
| vsync | output | 1 | Vertical sync at programmed polarity |
| de | output | 1 | Data enable, high in the active region |
| field | output | 1 | 0 = first field, 1 = second field |
| hcount | output | HW+2 | Pixel position within the line |
| vcount | output | VW+2 | Line position within the field |

## Verification
The bench builds the block with HW = 8 and VW = 8 and programs lines of at most about thirty pixels and fields of at most about eighteen lines. A full interlaced frame is then around a thousand cycles. With frames this short, dozens of configuration switches fit in one run: progressive, interlaced and half-line modes under all four polarity masks, and odd active heights. The run also reaches a commit landing on the frame's last cycle, two accepted commits in one frame, a rejected commit on top of a pending one, and a reset in mid-frame. Every cycle's outputs are compared against a cycle model written from the requirements.

// File: rtl/scan_timing_pkg.sv
// Shared definitions for the raster timing generator.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package scan_timing_pkg;

    // Horizontal position class, in the order the segments occur within a line.
    typedef enum logic [1:0] {
        HSEG_ACTIVE,
        HSEG_FRONT,
        HSEG_SYNC,
        HSEG_BACK
    } hseg_e;

    // Map an internal "sync asserted" flag to the pin level chosen by a polarity bit.
    function automatic logic drive_level(input logic asserted, input logic high_true);
        return high_true ? asserted : ~asserted;
    endfunction

endpackage

// File: rtl/scan_cfg_bank.sv
// Double buffer for the timing configuration.
// A committed word that is not flagged bad is captured into a pending slot.
// The pending slot is copied into the active slot on a frame-end cycle.
// Assumes: wr_bad is valid in the same cycle as wr_commit; frame_end is a
// single-cycle flag from the counters.
module scan_cfg_bank #(
    parameter int           CW      = 16,
    parameter logic [CW-1:0] RST_CFG = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_commit,
    input  logic          wr_bad,
    input  logic [CW-1:0] wr_cfg,
    input  logic          frame_end,
    output logic [CW-1:0] act_cfg,
    output logic          cfg_err
);

    logic [CW-1:0] pend_cfg;
    logic          pend_vld;

    // Capture accepted words, flag rejected ones, retire pending at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cfg  <= RST_CFG;
            pend_cfg <= '0;
            pend_vld <= 1'b0;
            cfg_err  <= 1'b0;
        end else begin
            cfg_err <= wr_commit && wr_bad;
            if (frame_end && pend_vld) begin
                act_cfg <= pend_cfg;
            end
            if (wr_commit && !wr_bad) begin
                pend_cfg <= wr_cfg;
                pend_vld <= 1'b1;
            end else if (frame_end) begin
                pend_vld <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/scan_field_sel.sv
// Derives the per-line and per-field boundaries from the active configuration.
// Picks the vertical set of the current field, halves the active height when
// interlaced, and enables mid-line vertical sync for field 0 in half-line mode.
// Assumes: inputs are register outputs, so this stage is purely combinational.
module scan_field_sel #(
    parameter int HW  = 12,
    parameter int VW  = 11,
    parameter int HTW = HW + 2,
    parameter int VTW = VW + 2
) (
    input  logic           field,
    input  logic           ilace,
    input  logic           half,
    input  logic [HW-1:0]  hact,
    input  logic [HW-1:0]  hfp,
    input  logic [HW-1:0]  hsw,
    input  logic [HW-1:0]  hbp,
    input  logic [VW-1:0]  vact,
    input  logic [VW-1:0]  v1fp,
    input  logic [VW-1:0]  v1sw,
    input  logic [VW-1:0]  v1bp,
    input  logic [VW-1:0]  v2fp,
    input  logic [VW-1:0]  v2sw,
    input  logic [VW-1:0]  v2bp,
    output logic [HTW-1:0] hact_x,
    output logic [HTW-1:0] hs_start,
    output logic [HTW-1:0] hs_end,
    output logic [HTW-1:0] htot,
    output logic [HTW-1:0] hmid,
    output logic [VTW-1:0] alines,
    output logic [VTW-1:0] vs_start,
    output logic [VTW-1:0] vs_end,
    output logic [VTW-1:0] ftot,
    output logic           mid_en
);

    logic [VW-1:0] sel_fp;
    logic [VW-1:0] sel_sw;
    logic [VW-1:0] sel_bp;

    // Horizontal boundaries: active, front porch, sync, back porch.
    always_comb begin
        hact_x   = HTW'(hact);
        hs_start = HTW'(hact) + HTW'(hfp);
        hs_end   = hs_start + HTW'(hsw);
        htot     = hs_end + HTW'(hbp);
        hmid     = htot >> 1;
    end

    // Vertical set of the field being scanned; field stays 0 when progressive.
    always_comb begin
        sel_fp = field ? v2fp : v1fp;
        sel_sw = field ? v2sw : v1sw;
        sel_bp = field ? v2bp : v1bp;
    end

    // Vertical boundaries of the current field.
    always_comb begin
        alines   = ilace ? VTW'(vact >> 1) : VTW'(vact);
        vs_start = alines + VTW'(sel_fp);
        vs_end   = vs_start + VTW'(sel_sw);
        ftot     = vs_end + VTW'(sel_bp);
        mid_en   = ilace && half && !field;
    end

endmodule

// File: rtl/scan_counters.sv
// Pixel, line and field counters.
// The pixel counter wraps at htot and the line counter wraps at the field total.
// The field bit toggles per field in interlaced mode and stays 0 otherwise.
// Assumes: htot and ftot are at least 1 (a zero total wraps every cycle).
module scan_counters #(
    parameter int HTW = 14,
    parameter int VTW = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [HTW-1:0] htot,
    input  logic [VTW-1:0] ftot,
    input  logic           ilace,
    output logic [HTW-1:0] hcnt,
    output logic [VTW-1:0] vcnt,
    output logic           field,
    output logic           frame_end
);

    logic line_last;
    logic field_last;

    // Detect the last pixel of the line, of the field and of the frame.
    always_comb begin
        line_last  = ((HTW+1)'(hcnt) + (HTW+1)'(1)) >= (HTW+1)'(htot);
        field_last = line_last && (((VTW+1)'(vcnt) + (VTW+1)'(1)) >= (VTW+1)'(ftot));
        frame_end  = field_last && (!ilace || field);
    end

    // Advance the raster position by one pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt  <= '0;
            vcnt  <= '0;
            field <= 1'b0;
        end else if (line_last) begin
            hcnt <= '0;
            if (field_last) begin
                vcnt  <= '0;
                field <= frame_end ? 1'b0 : 1'b1;
            end else begin
                vcnt <= vcnt + VTW'(1);
            end
        end else begin
            hcnt <= hcnt + HTW'(1);
        end
    end

endmodule

// File: rtl/scan_sync_decode.sv
// Turns the raster position into sync, data-enable and polarity-adjusted pins.
// Assumes: boundaries are ordered start <= end, as built by scan_field_sel.
module scan_sync_decode
    import scan_timing_pkg::*;
#(
    parameter int HTW = 14,
    parameter int VTW = 13
) (
    input  logic [HTW-1:0] hcnt,
    input  logic [VTW-1:0] vcnt,
    input  logic [HTW-1:0] hact_x,
    input  logic [HTW-1:0] hs_start,
    input  logic [HTW-1:0] hs_end,
    input  logic [HTW-1:0] hmid,
    input  logic [VTW-1:0] alines,
    input  logic [VTW-1:0] vs_start,
    input  logic [VTW-1:0] vs_end,
    input  logic           mid_en,
    input  logic [1:0]     pol,
    output logic           hs_act,
    output logic           hsync,
    output logic           vsync,
    output logic           de
);

    hseg_e hseg;
    logic  v_started;
    logic  v_not_done;
    logic  vs_act;

    // Classify the pixel within the line.
    always_comb begin
        if (hcnt < hact_x) begin
            hseg = HSEG_ACTIVE;
        end else if (hcnt < hs_start) begin
            hseg = HSEG_FRONT;
        end else if (hcnt < hs_end) begin
            hseg = HSEG_SYNC;
        end else begin
            hseg = HSEG_BACK;
        end
    end

    // Vertical sync window, with edges moved to mid-line when enabled.
    always_comb begin
        if (mid_en) begin
            v_started  = (vcnt > vs_start) || ((vcnt == vs_start) && (hcnt >= hmid));
            v_not_done = (vcnt < vs_end) || ((vcnt == vs_end) && (hcnt < hmid));
        end else begin
            v_started  = vcnt >= vs_start;
            v_not_done = vcnt < vs_end;
        end
        vs_act = v_started && v_not_done;
    end

    // Output pins.
    always_comb begin
        hs_act = (hseg == HSEG_SYNC);
        de     = (hseg == HSEG_ACTIVE) && (vcnt < alines);
        hsync  = drive_level(hs_act, pol[1]);
        vsync  = drive_level(vs_act, pol[0]);
    end

endmodule

// File: rtl/scan_timing_gen.sv
// Top of the programmable raster timing generator.
// Chain: configuration double buffer -> boundary derivation -> counters -> decode.
// Assumes: all inputs are in the pixel clock domain and reset is synchronous, active low.
module scan_timing_gen #(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_commit,
    input  logic            cfg_ilace,
    input  logic            cfg_half,
    input  logic [1:0]      cfg_pol,
    input  logic [HW-1:0]   cfg_hact,
    input  logic [HW-1:0]   cfg_hfp,
    input  logic [HW-1:0]   cfg_hsw,
    input  logic [HW-1:0]   cfg_hbp,
    input  logic [VW-1:0]   cfg_vact,
    input  logic [VW-1:0]   cfg_f1_vfp,
    input  logic [VW-1:0]   cfg_f1_vsw,
    input  logic [VW-1:0]   cfg_f1_vbp,
    input  logic [VW-1:0]   cfg_f2_vfp,
    input  logic [VW-1:0]   cfg_f2_vsw,
    input  logic [VW-1:0]   cfg_f2_vbp,
    output logic            cfg_err,
    output logic            hsync,
    output logic            vsync,
    output logic            de,
    output logic            field,
    output logic [HW+1:0]   hcount,
    output logic [VW+1:0]   vcount
);

    localparam int HTW = HW + 2;
    localparam int VTW = VW + 2;
    localparam int CW  = 4 + 4 * HW + 7 * VW;
    localparam logic [CW-1:0] RST_CFG = {
        1'b0, 1'b0, 2'b00,
        HW'(8), HW'(2), HW'(2), HW'(2),
        VW'(4), VW'(1), VW'(1), VW'(1),
        VW'(0), VW'(0), VW'(0)
    };

    logic [CW-1:0]  wr_cfg;
    logic           wr_bad;
    logic [CW-1:0]  act_cfg;
    logic           frame_end;

    logic           a_ilace;
    logic           a_half;
    logic [1:0]     a_pol;
    logic [HW-1:0]  a_hact, a_hfp, a_hsw, a_hbp;
    logic [VW-1:0]  a_vact, a_v1fp, a_v1sw, a_v1bp, a_v2fp, a_v2sw, a_v2bp;

    logic [HTW-1:0] hact_x, hs_start, hs_end, htot, hmid;
    logic [VTW-1:0] alines, vs_start, vs_end, ftot;
    logic           mid_en;
    logic           hs_act;

    // Pack the submitted set and check the second-field rule for progressive mode.
    always_comb begin
        wr_cfg = {cfg_ilace, cfg_half, cfg_pol,
                  cfg_hact, cfg_hfp, cfg_hsw, cfg_hbp,
                  cfg_vact, cfg_f1_vfp, cfg_f1_vsw, cfg_f1_vbp,
                  cfg_f2_vfp, cfg_f2_vsw, cfg_f2_vbp};
        wr_bad = !cfg_ilace && ((cfg_f2_vfp | cfg_f2_vsw | cfg_f2_vbp) != '0);
    end

    // Unpack the active set.
    assign {a_ilace, a_half, a_pol,
            a_hact, a_hfp, a_hsw, a_hbp,
            a_vact, a_v1fp, a_v1sw, a_v1bp,
            a_v2fp, a_v2sw, a_v2bp} = act_cfg;

    scan_cfg_bank #(
        .CW      (CW),
        .RST_CFG (RST_CFG)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_commit (cfg_commit),
        .wr_bad    (wr_bad),
        .wr_cfg    (wr_cfg),
        .frame_end (frame_end),
        .act_cfg   (act_cfg),
        .cfg_err   (cfg_err)
    );

    scan_field_sel #(
        .HW  (HW),
        .VW  (VW),
        .HTW (HTW),
        .VTW (VTW)
    ) u_sel (
        .field    (field),
        .ilace    (a_ilace),
        .half     (a_half),
        .hact     (a_hact),
        .hfp      (a_hfp),
        .hsw      (a_hsw),
        .hbp      (a_hbp),
        .vact     (a_vact),
        .v1fp     (a_v1fp),
        .v1sw     (a_v1sw),
        .v1bp     (a_v1bp),
        .v2fp     (a_v2fp),
        .v2sw     (a_v2sw),
        .v2bp     (a_v2bp),
        .hact_x   (hact_x),
        .hs_start (hs_start),
        .hs_end   (hs_end),
        .htot     (htot),
        .hmid     (hmid),
        .alines   (alines),
        .vs_start (vs_start),
        .vs_end   (vs_end),
        .ftot     (ftot),
        .mid_en   (mid_en)
    );

    scan_counters #(
        .HTW (HTW),
        .VTW (VTW)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .htot      (htot),
        .ftot      (ftot),
        .ilace     (a_ilace),
        .hcnt      (hcount),
        .vcnt      (vcount),
        .field     (field),
        .frame_end (frame_end)
    );

    scan_sync_decode #(
        .HTW (HTW),
        .VTW (VTW)
    ) u_dec (
        .hcnt     (hcount),
        .vcnt     (vcount),
        .hact_x   (hact_x),
        .hs_start (hs_start),
        .hs_end   (hs_end),
        .hmid     (hmid),
        .alines   (alines),
        .vs_start (vs_start),
        .vs_end   (vs_end),
        .mid_en   (mid_en),
        .pol      (a_pol),
        .hs_act   (hs_act),
        .hsync    (hsync),
        .vsync    (vsync),
        .de       (de)
    );

endmodule

// File: rtl/scan_timing_chk.sv
// Property checker for scan_timing_gen, attached through bind below.
// Assumes: clocked on the pixel clock with the same synchronous reset.
module scan_timing_chk #(
    parameter int HW  = 12,
    parameter int HTW = 14,
    parameter int VTW = 13,
    parameter int CW  = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic [HTW-1:0] hcount,
    input logic [VTW-1:0] vcount,
    input logic           field,
    input logic           de,
    input logic           hs_act,
    input logic           cfg_err,
    input logic           cfg_commit,
    input logic [CW-1:0]  act_cfg,
    input logic [HW-1:0]  act_hact,
    input logic           act_ilace
);

    // R1: the pixel counter only ever steps by one or returns to zero.
    p_hcount_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hcount != '0) |-> (hcount == $past(hcount) + HTW'(1)));

    // R2: horizontal sync and data enable never overlap.
    p_sync_no_de_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hs_act |-> !de);

    // R3: data enable stays inside the active width.
    p_de_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (hcount < HTW'(act_hact)));

    // R6: the second field exists only in interlaced mode.
    p_field_ilace_r6: assert property (@(posedge clk) disable iff (!rst_n)
        field |-> act_ilace);

    // R8: an error pulse always follows a commit.
    p_err_after_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(cfg_commit));

    // R9: the active set changes only at the frame origin.
    p_cfg_frame_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_cfg) |-> (hcount == '0 && vcount == '0 && !field));

    // R10: reset brings the raster back to its origin.
    p_reset_origin_r10: assert property (@(posedge clk)
        !rst_n |=> (hcount == '0 && vcount == '0 && !field && !cfg_err));

endmodule

bind scan_timing_gen scan_timing_chk #(
    .HW  (HW),
    .HTW (HTW),
    .VTW (VTW),
    .CW  (CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hcount     (hcount),
    .vcount     (vcount),
    .field      (field),
    .de         (de),
    .hs_act     (hs_act),
    .cfg_err    (cfg_err),
    .cfg_commit (cfg_commit),
    .act_cfg    (act_cfg),
    .act_hact   (a_hact),
    .act_ilace  (a_ilace)
);

// File: tb/scan_timing_gen_tb.sv
`timescale 1ns/1ps
module scan_timing_gen_tb;

    localparam int HW  = 8;
    localparam int VW  = 8;
    localparam int HTW = HW + 2;
    localparam int VTW = VW + 2;

    typedef struct {
        int hact, hfp, hsw, hbp;
        int vact, fp1, sw1, bp1, fp2, sw2, bp2;
        bit il, half;
        bit [1:0] pol;
    } mcfg_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic commit = 1'b0;
    mcfg_t drv;

    logic           cfg_err, hsync, vsync, de, field;
    logic [HTW-1:0] hcount;
    logic [VTW-1:0] vcount;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit chk_on = 1'b0;

    // model state
    mcfg_t m_act, m_pend;
    bit    m_pv, m_err, m_recent;
    int    m_h, m_v, m_f, m_frames;

    always #2 clk = ~clk;

    scan_timing_gen #(.HW(HW), .VW(VW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_commit (commit),
        .cfg_ilace  (drv.il),
        .cfg_half   (drv.half),
        .cfg_pol    (drv.pol),
        .cfg_hact   (HW'(drv.hact)),
        .cfg_hfp    (HW'(drv.hfp)),
        .cfg_hsw    (HW'(drv.hsw)),
        .cfg_hbp    (HW'(drv.hbp)),
        .cfg_vact   (VW'(drv.vact)),
        .cfg_f1_vfp (VW'(drv.fp1)),
        .cfg_f1_vsw (VW'(drv.sw1)),
        .cfg_f1_vbp (VW'(drv.bp1)),
        .cfg_f2_vfp (VW'(drv.fp2)),
        .cfg_f2_vsw (VW'(drv.sw2)),
        .cfg_f2_vbp (VW'(drv.bp2)),
        .cfg_err    (cfg_err),
        .hsync      (hsync),
        .vsync      (vsync),
        .de         (de),
        .field      (field),
        .hcount     (hcount),
        .vcount     (vcount)
    );

    function automatic mcfg_t rst_cfg();
        mcfg_t c;
        c.hact = 8; c.hfp = 2; c.hsw = 2; c.hbp = 2;
        c.vact = 4; c.fp1 = 1; c.sw1 = 1; c.bp1 = 1;
        c.fp2 = 0; c.sw2 = 0; c.bp2 = 0;
        c.il = 1'b0; c.half = 1'b0; c.pol = 2'b00;
        return c;
    endfunction

    function automatic int htot(mcfg_t c);
        return c.hact + c.hfp + c.hsw + c.hbp;
    endfunction

    function automatic int alines(mcfg_t c);
        return c.il ? c.vact / 2 : c.vact;
    endfunction

    function automatic int ftot(mcfg_t c, int f);
        return alines(c) + (f != 0 ? c.fp2 + c.sw2 + c.bp2 : c.fp1 + c.sw1 + c.bp1);
    endfunction

    function automatic bit is_bad(mcfg_t c);
        return !c.il && (c.fp2 != 0 || c.sw2 != 0 || c.bp2 != 0);
    endfunction

    function automatic bit model_frame_end();
        bit le, fe;
        le = (m_h + 1 >= htot(m_act));
        fe = le && (m_v + 1 >= ftot(m_act, m_f));
        return fe && (!m_act.il || m_f == 1);
    endfunction

    function automatic mcfg_t rand_cfg(bit il, bit half);
        mcfg_t c;
        c.hact = $urandom_range(20, 4);
        c.hfp  = $urandom_range(3, 0);
        c.hsw  = $urandom_range(4, 1);
        c.hbp  = $urandom_range(3, 0);
        c.vact = $urandom_range(8, 2);
        c.fp1  = $urandom_range(3, 0);
        c.sw1  = $urandom_range(3, 1);
        c.bp1  = $urandom_range(3, 0);
        c.il   = il;
        c.half = half;
        c.pol  = 2'($urandom_range(3, 0));
        if (il) begin
            c.fp2 = $urandom_range(3, 0);
            c.sw2 = $urandom_range(3, 0);
            c.bp2 = $urandom_range(3, 0);
        end else begin
            c.fp2 = 0; c.sw2 = 0; c.bp2 = 0;
        end
        return c;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // cycle model, updated on the same edge as the design
    always @(posedge clk) begin
        bit le, fe, fre;
        if (!rst_n) begin
            m_act = rst_cfg(); m_pend = rst_cfg(); m_pv = 0; m_err = 0;
            m_h = 0; m_v = 0; m_f = 0; m_recent = 0;
        end else begin
            le  = (m_h + 1 >= htot(m_act));
            fe  = le && (m_v + 1 >= ftot(m_act, m_f));
            fre = fe && (!m_act.il || m_f == 1);
            m_err = commit && is_bad(drv);
            if (fre && m_pv) begin
                m_act = m_pend;
                m_recent = 1;
            end
            if (commit && !is_bad(drv)) begin
                m_pend = drv;
                m_pv = 1;
            end else if (fre) begin
                m_pv = 0;
            end
            if (le) begin
                m_h = 0;
                if (fe) begin
                    m_v = 0;
                    m_f = fre ? 0 : 1;
                end else begin
                    m_v++;
                    m_recent = 0;
                end
            end else begin
                m_h++;
            end
            if (fre) m_frames++;
        end
        chk_on = 1'b1;
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        int s, e, mid;
        bit hs, vs, dex, use_mid;
        if (chk_on && !done) begin
            hs  = (m_h >= m_act.hact + m_act.hfp) && (m_h < m_act.hact + m_act.hfp + m_act.hsw);
            dex = (m_h < m_act.hact) && (m_v < alines(m_act));
            s   = alines(m_act) + (m_f != 0 ? m_act.fp2 : m_act.fp1);
            e   = s + (m_f != 0 ? m_act.sw2 : m_act.sw1);
            mid = htot(m_act) / 2;
            use_mid = m_act.il && m_act.half && (m_f == 0);
            if (use_mid)
                vs = ((m_v > s) || (m_v == s && m_h >= mid)) && ((m_v < e) || (m_v == e && m_h < mid));
            else
                vs = (m_v >= s) && (m_v < e);
            chk((m_recent && m_v == 0 && m_f == 0) ? "R9" : "R1", "hcount", int'(hcount), m_h);
            chk("R4", "vcount", int'(vcount), m_v);
            chk("R2", "hsync", int'(hsync), int'(m_act.pol[1] ? hs : !hs));
            chk("R3", "de", int'(de), int'(dex));
            chk(use_mid ? "R7" : "R5", "vsync", int'(vsync), int'(m_act.pol[0] ? vs : !vs));
            chk("R6", "field", int'(field), m_f);
            chk("R8", "cfg_err", int'(cfg_err), int'(m_err));
        end
    end

    task automatic wait_frames(int n);
        int target;
        target = m_frames + n;
        while (m_frames < target) @(negedge clk);
    endtask

    task automatic do_commit(mcfg_t c);
        drv = c;
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        if (is_bad(c)) chk("R8", "cfg_err after rejected commit", int'(cfg_err), 1);
    endtask

    task automatic reset_checks();
        chk("R10", "hcount", int'(hcount), 0);
        chk("R10", "vcount", int'(vcount), 0);
        chk("R10", "field", int'(field), 0);
        chk("R10", "cfg_err", int'(cfg_err), 0);
        chk("R10", "hsync idle high", int'(hsync), 1);
        chk("R10", "vsync idle high", int'(vsync), 1);
        chk("R10", "de at origin", int'(de), 1);
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        mcfg_t c, c2;
        int unused_seed;
        unused_seed = $urandom(32'd4711);
        m_frames = 0;
        drv = rst_cfg();
        repeat (3) @(negedge clk);
        reset_checks();
        rst_n = 1'b1;
        wait_frames(1);

        // directed: progressive, interlaced, interlaced with half line
        c = rand_cfg(1'b0, 1'b0); c.pol = 2'b10; do_commit(c); wait_frames(2);
        c = rand_cfg(1'b1, 1'b0); c.pol = 2'b01; do_commit(c); wait_frames(2);
        c = rand_cfg(1'b1, 1'b1); c.pol = 2'b11; c.vact = 7; do_commit(c); wait_frames(2);
        // half flag set in progressive mode: no effect (R7)
        c = rand_cfg(1'b0, 1'b1); do_commit(c); wait_frames(2);

        // rejected commit keeps the running set (R8)
        c = rand_cfg(1'b0, 1'b0); c.bp2 = 2; do_commit(c); wait_frames(2);

        // two accepted commits in one frame: latest wins (R9)
        c = rand_cfg(1'b1, 1'b1); do_commit(c);
        repeat (5) @(negedge clk);
        c2 = rand_cfg(1'b0, 1'b0); do_commit(c2); wait_frames(2);

        // good commit then rejected one: pending survives (R8)
        c = rand_cfg(1'b1, 1'b0); do_commit(c);
        c2 = rand_cfg(1'b0, 1'b0); c2.sw2 = 1; do_commit(c2); wait_frames(2);

        // commit landing in the last cycle of the frame (R9)
        @(negedge clk);
        while (!model_frame_end()) @(negedge clk);
        c = rand_cfg(1'b1, 1'b1); do_commit(c); wait_frames(3);

        // reset in mid-frame (R10)
        repeat (37) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        reset_checks();
        rst_n = 1'b1;
        wait_frames(1);

        // constrained random
        for (int i = 0; i < 20; i++) begin
            c = rand_cfg(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
            if (i % 6 == 5) begin
                c.il = 1'b0;
                c.fp2 = $urandom_range(3, 1);
            end
            do_commit(c);
            repeat ($urandom_range(300, 0)) @(negedge clk);
            if ($urandom_range(1, 0) == 1) begin
                c2 = rand_cfg(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
                do_commit(c2);
            end
            wait_frames(2);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule